// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multiple-register memory transfer command into a stream of single-word beats. A command carries a register selection mask, a base address and three mode bits: step direction, pre/post indexing and base update. The sequencer issues one beat per selected register. Each beat gives the register index, the word address, a final-beat marker and a pass-through flag that asks for the unprivileged register bank.

Registers always leave in ascending index order at ascending addresses, whichever direction the mode selects. The block therefore counts the selected registers when it accepts the command and computes the lowest address from that count before the first beat. Every later beat is one word above the one before it. A ready/valid pair on the beat port lets the memory side hold the sequence for any number of cycles. When the final beat is taken, the block presents the updated base value for one cycle, together with the update-enable bit from the command. A command with an empty mask issues no beats and raises a one-cycle error pulse instead.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, cmd_ready is 1 and beat_valid, wb_valid and err_empty are 0.
- R2: Each command with a non-empty mask produces exactly one beat per set mask bit (bit i selects register i). Beats come in ascending register index, and beat_last is 1 only on the highest selected index.
- R3: With up=1 and pre=0 (increment-after), the first beat address is base.
- R4: With up=1 and pre=1 (increment-before), the first beat address is base+4.
- R5: With up=0 and pre=0 (decrement-after), the first beat address is base-4n+4, where n is the number of set mask bits. Arithmetic is modulo 2^32.
- R6: With up=0 and pre=1 (decrement-before), the first beat address is base-4n.
- R7: Each beat after the first has an address 4 above the previous beat's address.
- R8: In the cycle after the final beat is accepted, wb_valid is 1 for exactly one cycle. wb_value is then base+4n when up=1 and base-4n when up=0, and wb_en equals the command's update bit.
- R9: While beat_valid is 1 and beat_ready is 0, beat_reg, beat_addr, beat_last and beat_user hold their values.
- R10: A command with an all-zero mask raises err_empty for one cycle, in the cycle after it is accepted. It produces no beat and no wb_valid.
- R11: beat_user on every beat equals the user flag given with the command.
- R12: From command acceptance until the sequence finishes, cmd_ready is 0, and commands offered in that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle; command taken when both are high |
| cmd_list | input | 16 | Register selection mask, bit i = register i |
| cmd_base | input | 32 | Base address |
| cmd_pre | input | 1 | 1 = step before each access, 0 = after |
| cmd_up | input | 1 | 1 = increment, 0 = decrement |
| cmd_wb | input | 1 | 1 = base is to be updated |
| cmd_user | input | 1 | Unprivileged-bank flag, passed to beats |
| beat_valid | output | 1 | Beat presented |
| beat_ready | input | 1 | Memory side takes the beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_addr | output | 32 | Word address of the beat |
| beat_last | output | 1 | Final beat of the command |
| beat_user | output | 1 | Copy of cmd_user |
| wb_valid | output | 1 | Updated base presented (one cycle) |
| wb_en | output | 1 | Copy of cmd_wb, meaningful with wb_valid |
| wb_value | output | 32 | Updated base value |
| err_empty | output | 1 | Empty-mask command pulse |

## Verification
The first beat appears in the cycle after the command handshake edge. Each further beat follows the edge on which the previous beat was taken. wb_valid rises exactly one cycle after the edge that takes the final beat, and err_empty one cycle after an empty command is taken. A scoreboard queues the expected beats, base updates and error pulses when each command is driven. The monitor samples on the falling edge, so every handshake and every one-cycle pulse is judged half a period after the rising edge that produced it. It also flags a base update whose cycle does not follow the final beat, and any beat field that moves while the beat is held.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } seq_state_e;

endpackage

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [IW-1:0]   idx,
  output logic [NREG-1:0] rest,
  output logic            last
);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end

  assign rest = mask & (mask - NREG'(1));
  assign last = (rest == '0);

endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int WB   = 4,
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] list,
  input  logic [AW-1:0]   base,
  input  logic            pre,
  input  logic            up,
  output logic [AW-1:0]   first,
  output logic [AW-1:0]   wbv,
  output logic            empty
);

  function automatic logic [CW-1:0] count_set(input logic [NREG-1:0] m);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CW'(m[i]);
    return c;
  endfunction

  function automatic logic [AW-1:0] lowest_addr(input logic [AW-1:0] b,
                                                input logic [AW-1:0] span,
                                                input logic p, input logic u);
    logic [AW-1:0] r;
    if (u) r = p ? b + AW'(WB) : b;
    else   r = p ? b - span : b - span + AW'(WB);
    return r;
  endfunction

  function automatic logic [AW-1:0] updated_base(input logic [AW-1:0] b,
                                                 input logic [AW-1:0] span,
                                                 input logic u);
    return u ? b + span : b - span;
  endfunction

  logic [CW-1:0] n_set;
  logic [AW-1:0] span;

  assign n_set = count_set(list);
  assign span  = AW'(n_set) * AW'(WB);
  assign first = lowest_addr(base, span, pre, up);
  assign wbv   = updated_base(base, span, up);
  assign empty = (n_set == '0);

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int WB   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NREG-1:0] cmd_list,
  input  logic [AW-1:0]   cmd_base,
  input  logic            cmd_pre,
  input  logic            cmd_up,
  input  logic            cmd_wb,
  input  logic            cmd_user,
  output logic            beat_valid,
  input  logic            beat_ready,
  output logic [IW-1:0]   beat_reg,
  output logic [AW-1:0]   beat_addr,
  output logic            beat_last,
  output logic            beat_user,
  output logic            wb_valid,
  output logic            wb_en,
  output logic [AW-1:0]   wb_value,
  output logic            err_empty
);
  import blkxfer_pkg::*;

  seq_state_e      state;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   wbv_q;
  logic            user_q;
  logic            wen_q;

  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   next_base;
  logic            list_empty;
  logic [IW-1:0]   pick_idx;
  logic [NREG-1:0] pick_rest;
  logic            pick_last;

  // named events for the checks
  logic cmd_fire;
  logic beat_fire;
  logic seq_end;

  blkxfer_addr #(.NREG(NREG), .AW(AW), .WB(WB)) u_addr (
    .list  (cmd_list),
    .base  (cmd_base),
    .pre   (cmd_pre),
    .up    (cmd_up),
    .first (first_addr),
    .wbv   (next_base),
    .empty (list_empty)
  );

  blkxfer_pick #(.NREG(NREG)) u_pick (
    .mask (mask_q),
    .idx  (pick_idx),
    .rest (pick_rest),
    .last (pick_last)
  );

  assign cmd_ready  = (state == ST_IDLE);
  assign beat_valid = (state == ST_RUN);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign beat_fire  = beat_valid && beat_ready;
  assign seq_end    = beat_fire && pick_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mask_q <= '0;
      addr_q <= '0;
      wbv_q  <= '0;
      user_q <= 1'b0;
      wen_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_fire) begin
            if (list_empty) begin
              state <= ST_FAULT;
            end else begin
              state  <= ST_RUN;
              mask_q <= cmd_list;
              addr_q <= first_addr;
              wbv_q  <= next_base;
              user_q <= cmd_user;
              wen_q  <= cmd_wb;
            end
          end
        end
        ST_RUN: begin
          if (beat_fire) begin
            mask_q <= pick_rest;
            addr_q <= addr_q + AW'(WB);
            if (pick_last) state <= ST_DONE;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign beat_reg  = pick_idx;
  assign beat_addr = addr_q;
  assign beat_last = pick_last;
  assign beat_user = user_q;
  assign wb_valid  = (state == ST_DONE);
  assign wb_en     = wen_q;
  assign wb_value  = wbv_q;
  assign err_empty = (state == ST_FAULT);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
      $stable(beat_reg) && $stable(beat_last) && $stable(beat_user));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> beat_valid &&
      (beat_addr - $past(beat_addr) == AW'(WB)));

  // R2
  reg_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> beat_valid && (beat_reg > $past(beat_reg)));

  // R2
  reg_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> mask_q[beat_reg]);

  // R8
  wb_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> wb_valid && !beat_valid);

  // R8
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_empty |-> !beat_valid && !wb_valid && !cmd_ready);

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !cmd_ready);

endmodule

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_list = '0;
  logic [31:0] cmd_base = '0;
  logic        cmd_pre = 1'b0, cmd_up = 1'b0, cmd_wb = 1'b0, cmd_user = 1'b0;
  logic        beat_valid;
  logic        beat_ready = 1'b1;
  logic [3:0]  beat_reg;
  logic [31:0] beat_addr;
  logic        beat_last, beat_user;
  logic        wb_valid, wb_en;
  logic [31:0] wb_value;
  logic        err_empty;

  always #5 clk = ~clk;

  blkxfer_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_list(cmd_list),
    .cmd_base(cmd_base), .cmd_pre(cmd_pre), .cmd_up(cmd_up), .cmd_wb(cmd_wb),
    .cmd_user(cmd_user), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_reg(beat_reg), .beat_addr(beat_addr), .beat_last(beat_last),
    .beat_user(beat_user), .wb_valid(wb_valid), .wb_en(wb_en),
    .wb_value(wb_value), .err_empty(err_empty)
  );

  typedef struct { int r; logic [31:0] a; bit l; bit u; } beat_t;
  typedef struct { logic [31:0] v; bit e; } wb_t;

  beat_t exp_beats[$];
  wb_t   exp_wb[$];
  int    exp_err = 0;
  int    checks = 0;
  int    errors = 0;
  bit    stall_mode = 1'b0;
  logic [31:0] rnd = 32'h1234_5679;
  bit    finished = 1'b0;

  function automatic logic [31:0] step_rnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // beat_ready driver, moves just after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      rnd = step_rnd(rnd);
      beat_ready = stall_mode ? (rnd[3:0] > 4'd5) : 1'b1;
    end
  end

  // expected stream, worked out from the lowest address upward
  task automatic expect_cmd(input logic [15:0] l, input logic [31:0] b,
                            input bit p, input bit up, input bit w, input bit usr);
    int n;
    int seen;
    logic [31:0] lo;
    n = 0;
    for (int i = 0; i < 16; i++) if (l[i]) n++;
    if (n == 0) begin
      exp_err++;
      return;
    end
    if (up) lo = p ? b + 32'd4 : b;
    else    lo = p ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
    seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (l[i]) begin
        beat_t e;
        seen++;
        e.r = i; e.a = lo; e.l = (seen == n); e.u = usr;
        exp_beats.push_back(e);
        lo = lo + 32'd4;
      end
    end
    begin
      wb_t x;
      x.v = up ? b + 32'(4 * n) : b - 32'(4 * n);
      x.e = w;
      exp_wb.push_back(x);
    end
  endtask

  task automatic send(input logic [15:0] l, input logic [31:0] b,
                      input bit p, input bit up, input bit w, input bit usr,
                      input int busy_pokes);
    @(posedge clk); #1;
    while (!cmd_ready) begin @(posedge clk); #1; end
    expect_cmd(l, b, p, up, w, usr);
    cmd_list = l; cmd_base = b; cmd_pre = p; cmd_up = up; cmd_wb = w; cmd_user = usr;
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (l == 16'h0) begin
      @(negedge clk);
      check(err_empty == 1'b1, "R10", "err_empty one cycle after empty cmd", 32'(err_empty), 32'd1);
    end
    for (int k = 0; k < busy_pokes; k++) begin
      // R12: garbage command while busy must be refused and leave no trace
      cmd_list = 16'hA5A5; cmd_base = 32'hDEAD_0000; cmd_up = ~up;
      cmd_valid = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b0, "R12", "cmd_ready while busy", 32'(cmd_ready), 32'd0);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
    end
    while (!cmd_ready) begin @(posedge clk); #1; end
  endtask

  // monitor / scoreboard
  initial begin
    bit pend_wb;
    bit held;
    logic [31:0] h_addr;
    logic [3:0]  h_reg;
    logic        h_last, h_user;
    pend_wb = 1'b0;
    held = 1'b0;
    h_addr = '0; h_reg = '0; h_last = 1'b0; h_user = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (held) begin
        check(beat_valid && beat_addr == h_addr && beat_reg == h_reg &&
              beat_last == h_last && beat_user == h_user,
              "R9", "beat held under stall", beat_addr, h_addr);
      end
      held = beat_valid && !beat_ready;
      h_addr = beat_addr; h_reg = beat_reg; h_last = beat_last; h_user = beat_user;

      if (pend_wb) begin
        check(wb_valid == 1'b1, "R8", "wb_valid the cycle after last beat", 32'(wb_valid), 32'd1);
      end else if (wb_valid) begin
        check(1'b0, "R8", "wb_valid without a final beat", 32'd1, 32'd0);
      end
      if (wb_valid) begin
        if (exp_wb.size() == 0) begin
          check(1'b0, "R8", "unexpected base update", wb_value, 32'd0);
        end else begin
          wb_t x;
          x = exp_wb.pop_front();
          check(wb_value == x.v, "R8", "wb_value", wb_value, x.v);
          check(wb_en == x.e, "R8", "wb_en follows update bit", 32'(wb_en), 32'(x.e));
        end
      end
      pend_wb = 1'b0;

      if (err_empty) begin
        check(exp_err > 0 && !beat_valid && !wb_valid, "R10", "error pulse alone",
              32'(exp_err), 32'd1);
        if (exp_err > 0) exp_err--;
      end

      if (beat_valid && beat_ready) begin
        if (exp_beats.size() == 0) begin
          check(1'b0, "R2", "unexpected beat", beat_addr, 32'd0);
        end else begin
          beat_t e;
          e = exp_beats.pop_front();
          check(int'(beat_reg) == e.r, "R2", "beat register order", 32'(beat_reg), 32'(e.r));
          check(beat_addr == e.a, "R7", "beat address (R3 R4 R5 R6 first beat)", beat_addr, e.a);
          check(beat_last == e.l, "R2", "beat_last", 32'(beat_last), 32'(e.l));
          check(beat_user == e.u, "R11", "beat_user", 32'(beat_user), 32'(e.u));
        end
        pend_wb = beat_last;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(cmd_ready == 1'b1, "R1", "cmd_ready in reset", 32'(cmd_ready), 32'd1);
    check(!beat_valid && !wb_valid && !err_empty, "R1", "outputs quiet in reset",
          {29'd0, beat_valid, wb_valid, err_empty}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !beat_valid && !wb_valid && !err_empty, "R1", "idle after reset",
          {28'd0, cmd_ready, beat_valid, wb_valid, err_empty}, 32'h8);

    // R3 increment-after, single register
    send(16'h0001, 32'h0000_0100, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    // R4 increment-before, scattered list
    send(16'h8421, 32'h0000_2000, 1'b1, 1'b1, 1'b0, 1'b1, 0);
    // R5 decrement-after, full list
    send(16'hFFFF, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    // R6 decrement-before
    send(16'h00F0, 32'h0000_0400, 1'b1, 1'b0, 1'b1, 1'b1, 0);
    // R6 wrap below zero
    send(16'h0007, 32'h0000_0008, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    // R10 empty list
    send(16'h0000, 32'h0000_0040, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    // R12 refused commands during a long run
    send(16'hFFFF, 32'h0001_0000, 1'b0, 1'b1, 1'b1, 1'b1, 5);
    // R9 stalls from the memory side
    stall_mode = 1'b1;
    send(16'h0F0F, 32'h0000_3000, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    send(16'hC003, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    for (int t = 0; t < 60; t++) begin
      logic [31:0] r1, r2;
      rnd = step_rnd(rnd); r1 = rnd;
      rnd = step_rnd(rnd); r2 = rnd;
      stall_mode = r2[31];
      send((t % 17 == 16) ? 16'h0000 : r1[15:0], {r2[29:2], 2'b00},
           r1[16], r1[17], r1[18], r1[19], 0);
    end
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_beats.size() == 0, "R2", "all expected beats seen", 32'(exp_beats.size()), 32'd0);
    check(exp_wb.size() == 0, "R8", "all base updates seen", 32'(exp_wb.size()), 32'd0);
    check(exp_err == 0, "R10", "all error pulses seen", 32'(exp_err), 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule